// File: doc/BRIEF.md
# Trap and Status Control Unit

This block holds the privileged control state of a small 32-bit CPU and sequences its traps. It keeps these registers:

- a status word with a three-deep stack of mode and interrupt-enable pairs, plus two cache-control bits;
- the trap cause, the PC of the trapping instruction and the faulting virtual address;
- a scratch word for the kernel;
- three vector targets: general, TLB miss and machine call;
- a context word assembled from the faulting address.

Several trap sources can request in the same cycle. The unit picks one and records it, pushes the status stack, and hands the fetch stage a redirect PC one cycle later.

The same unit serves the move-to and move-from extended-register instructions through a small address/data port. Reads are registered. Writes are blocked in user mode, where they raise a permission trap. Return-from-trap pops the status stack and redirects fetch to the saved trap PC. The TLB-side extended registers live elsewhere: their indices and data only pass through this block.

Top module: `trap_ctl`

## Requirements
- R1: After a synchronous reset, the status reads 0x01 (kernel mode, interrupts off), no redirect is signalled, and every local extended register other than status reads 0.
- R2: A taken trap sets status[5:0] to {status[3:0], 2'b01} and keeps status[7:6].
- R3: A return-from-trap with no trap in the same cycle copies status[5:2] into status[3:0]. It keeps status[7:4] and redirects fetch to the saved trap PC.
- R4: A taken trap stores its cause code and the trap PC input. On the next cycle it raises redirect_valid_o and trap_taken_o for exactly one cycle.
- R5: The redirect target is chosen as follows: the TLB-miss vector (address 0x06) for cause 3, the machine-call vector (0x07) for a kernel-mode mcall, and the general vector (0x05) for everything else.
- R6: The bad-address register (0x03) takes the trap address input only for causes 3 to 9. Other causes leave it unchanged.
- R7: The context register (0x15) reads as follows: bits 31:21 are the value written by software, bits 20:2 are bad-address bits 30:12, and bits 1:0 are 0.
- R8: Request bit k of trap_req_i means cause k (1 to 12). When several bits are set, the lowest code from 2 to 12 wins. Cause 1 (external) wins only when no other bit is set.
- R9: A syscall request (cause 2) with is_mcall_i high in user mode (status[0]=0) becomes a permission trap (cause 11). With is_mcall_i low (kcall), cause 2 is taken in either mode.
- R10: An extended-register write in user mode raises cause 11 and leaves the target register unchanged.
- R11: Reads return the addressed register one cycle after the address is presented. The local addresses are 0x00 to 0x07 and 0x15. Other addresses in 0x10 to 0x16 return tlb_rd_data_i. Every other address reads 0. A status write takes wdata[7:0].
- R12: A kernel write to 0x10 to 0x14 or 0x16 produces, one cycle later, a single-cycle tlb_wr_en_o pulse with index addr[2:0] and the write data. A write to 0x15 produces no pulse.
- R13: A trap taken in the same cycle as a return-from-trap or an extended-register write wins. The write is dropped and the redirect goes to the trap vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req_i | input | 12 | Trap requests; bit k means cause k, bits 12:1 |
| is_mcall_i | input | 1 | Qualifies a cause-2 request as a machine call |
| trap_pc_i | input | 32 | PC of the instruction being trapped |
| trap_vaddr_i | input | 32 | Faulting virtual address |
| rft_i | input | 1 | Return-from-trap request |
| ex_addr_i | input | 5 | Extended-register address |
| ex_we_i | input | 1 | Extended-register write strobe |
| ex_wdata_i | input | 32 | Extended-register write data |
| ex_rdata_o | output | 32 | Registered extended-register read data |
| tlb_rd_data_i | input | 32 | Read data from the TLB-side register at tlb_rd_idx_o |
| tlb_rd_idx_o | output | 3 | TLB-side register index for reads |
| tlb_wr_en_o | output | 1 | TLB-side register write pulse |
| tlb_wr_idx_o | output | 3 | TLB-side register write index |
| tlb_wr_data_o | output | 32 | TLB-side register write data |
| status_o | output | 8 | Current status word |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Fetch redirect target |
| trap_taken_o | output | 1 | A trap was taken on the previous cycle |

## Verification
The bench drives every cause alone and every pair of causes together.

- The pair sweep shows whether the external request is wrongly allowed to beat a higher code, and whether an inverted priority picks the highest code.
- The single-cause sweep shows whether the bad-address register is written for a non-address fault, or skipped for an address fault.
- A push or pop whose shift direction is wrong, or that clobbers the cache bits, shows up as a wrong status word after a trap followed by a return.
- User-mode mcalls and writes catch a design that lets them through: it would vector to the mcall target or overwrite the register.
- Same-cycle write/trap and return/trap cases catch a design that lets the write or the return win.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE   = 4'd0,
    C_EXT    = 4'd1,
    C_SYSC   = 4'd2,
    C_TMISS  = 4'd3,
    C_TMOD   = 4'd4,
    C_TINV   = 4'd5,
    C_MISRD  = 4'd6,
    C_MISWR  = 4'd7,
    C_FETCH  = 4'd8,
    C_DATA   = 4'd9,
    C_DIVZ   = 4'd10,
    C_PERM   = 4'd11,
    C_BADOP  = 4'd12
  } cause_e;

  localparam logic [4:0] XA_STATUS = 5'h00;
  localparam logic [4:0] XA_CAUSE  = 5'h01;
  localparam logic [4:0] XA_EPC    = 5'h02;
  localparam logic [4:0] XA_BADVA  = 5'h03;
  localparam logic [4:0] XA_SCR    = 5'h04;
  localparam logic [4:0] XA_VGEN   = 5'h05;
  localparam logic [4:0] XA_VMISS  = 5'h06;
  localparam logic [4:0] XA_VMCALL = 5'h07;
  localparam logic [4:0] XA_CTX    = 5'h15;

  function automatic logic is_addr_fault(input logic [CAUSE_W-1:0] c);
    return (c >= C_TMISS) && (c <= C_DATA);
  endfunction

  function automatic logic is_tlb_side(input logic [4:0] a);
    return a[4] && !a[3] && (a[2:0] != 3'd7) && (a != XA_CTX);
  endfunction

endpackage

// File: rtl/trap_arb.sv
module trap_arb #(
  parameter int NREQ = 13,
  parameter int CW   = 4
) (
  input  logic [NREQ-1:1] req,
  output logic            valid,
  output logic [CW-1:0]   code
);
  always_comb begin
    valid = |req;
    code  = '0;
    for (int k = NREQ - 1; k >= 2; k--) begin
      if (req[k]) code = CW'(k);
    end
    if (code == '0 && req[1]) code = CW'(1);
  end
endmodule

// File: rtl/status_stack.sv
module status_stack #(
  parameter int SW = 8,
  parameter logic [SW-1:0] RST_VAL = 8'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  output logic [SW-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= RST_VAL;
    end else if (push) begin
      st_q[5:0] <= {st_q[3:0], 2'b01};
    end else if (pop) begin
      st_q[3:0] <= st_q[5:2];
    end else if (wr_en) begin
      st_q <= wr_data;
    end
  end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_ctl_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int XA_W       = 5,
  parameter int NCAUSE     = 13,
  parameter int PAGE_SHIFT = 12,
  parameter int CTX_LSB    = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:1] trap_req_i,
  input  logic              is_mcall_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic [XLEN-1:0]   trap_vaddr_i,
  input  logic              rft_i,
  input  logic [XA_W-1:0]   ex_addr_i,
  input  logic              ex_we_i,
  input  logic [XLEN-1:0]   ex_wdata_i,
  output logic [XLEN-1:0]   ex_rdata_o,
  input  logic [XLEN-1:0]   tlb_rd_data_i,
  output logic [2:0]        tlb_rd_idx_o,
  output logic              tlb_wr_en_o,
  output logic [2:0]        tlb_wr_idx_o,
  output logic [XLEN-1:0]   tlb_wr_data_o,
  output logic [7:0]        status_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              trap_taken_o
);
  localparam int VPN_W  = CTX_LSB - 2;
  localparam int BASE_W = XLEN - CTX_LSB;

  logic [CAUSE_W-1:0] cause_q;
  logic [XLEN-1:0]    epc_q, badva_q, scr_q, vgen_q, vmiss_q, vmcall_q;
  logic [BASE_W-1:0]  ctx_base_q;
  logic [XLEN-1:0]    ctx_w;

  logic               user_m, mcall_bad, mtex_bad;
  logic [NCAUSE-1:1]  eff_req;
  logic               take;
  logic [CAUSE_W-1:0] win;
  logic               do_rft, wr_ok;
  logic [XLEN-1:0]    target;

  assign user_m    = ~status_o[0];
  assign mcall_bad = trap_req_i[C_SYSC] & is_mcall_i & user_m;
  assign mtex_bad  = ex_we_i & user_m;

  always_comb begin
    eff_req = trap_req_i;
    if (mcall_bad) begin
      eff_req[C_SYSC] = 1'b0;
      eff_req[C_PERM] = 1'b1;
    end
    if (mtex_bad) eff_req[C_PERM] = 1'b1;
  end

  trap_arb #(.NREQ(NCAUSE), .CW(CAUSE_W)) u_arb (
    .req   (eff_req),
    .valid (take),
    .code  (win)
  );

  assign do_rft = rft_i & ~take;
  assign wr_ok  = ex_we_i & ~user_m & ~take;

  always_comb begin
    if (win == C_TMISS)
      target = vmiss_q;
    else if (win == C_SYSC && is_mcall_i)
      target = vmcall_q;
    else
      target = vgen_q;
  end

  status_stack #(.SW(8), .RST_VAL(8'h01)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .push    (take),
    .pop     (do_rft),
    .wr_en   (wr_ok && ex_addr_i == XA_STATUS),
    .wr_data (ex_wdata_i[7:0]),
    .st_q    (status_o)
  );

  assign ctx_w = {ctx_base_q, badva_q[PAGE_SHIFT+VPN_W-1:PAGE_SHIFT], 2'b00};

  // Trap bookkeeping and software-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q    <= '0;
      epc_q      <= '0;
      badva_q    <= '0;
      scr_q      <= '0;
      vgen_q     <= '0;
      vmiss_q    <= '0;
      vmcall_q   <= '0;
      ctx_base_q <= '0;
    end else if (take) begin
      cause_q <= win;
      epc_q   <= trap_pc_i;
      if (is_addr_fault(win)) badva_q <= trap_vaddr_i;
    end else if (wr_ok) begin
      case (ex_addr_i)
        XA_CAUSE:  cause_q    <= ex_wdata_i[CAUSE_W-1:0];
        XA_EPC:    epc_q      <= ex_wdata_i;
        XA_BADVA:  badva_q    <= ex_wdata_i;
        XA_SCR:    scr_q      <= ex_wdata_i;
        XA_VGEN:   vgen_q     <= ex_wdata_i;
        XA_VMISS:  vmiss_q    <= ex_wdata_i;
        XA_VMCALL: vmcall_q   <= ex_wdata_i;
        XA_CTX:    ctx_base_q <= ex_wdata_i[XLEN-1:CTX_LSB];
        default: ;
      endcase
    end
  end

  // Fetch redirect
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      trap_taken_o     <= 1'b0;
    end else begin
      redirect_valid_o <= take | do_rft;
      redirect_pc_o    <= take ? target : epc_q;
      trap_taken_o     <= take;
    end
  end

  // TLB-side pass-through
  assign tlb_rd_idx_o = ex_addr_i[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tlb_wr_en_o   <= 1'b0;
      tlb_wr_idx_o  <= '0;
      tlb_wr_data_o <= '0;
    end else begin
      tlb_wr_en_o   <= wr_ok && is_tlb_side(ex_addr_i);
      tlb_wr_idx_o  <= ex_addr_i[2:0];
      tlb_wr_data_o <= ex_wdata_i;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_rdata_o <= '0;
    end else begin
      case (ex_addr_i)
        XA_STATUS: ex_rdata_o <= {{(XLEN-8){1'b0}}, status_o};
        XA_CAUSE:  ex_rdata_o <= {{(XLEN-CAUSE_W){1'b0}}, cause_q};
        XA_EPC:    ex_rdata_o <= epc_q;
        XA_BADVA:  ex_rdata_o <= badva_q;
        XA_SCR:    ex_rdata_o <= scr_q;
        XA_VGEN:   ex_rdata_o <= vgen_q;
        XA_VMISS:  ex_rdata_o <= vmiss_q;
        XA_VMCALL: ex_rdata_o <= vmcall_q;
        XA_CTX:    ex_rdata_o <= ctx_w;
        default:   ex_rdata_o <= is_tlb_side(ex_addr_i) ? tlb_rd_data_i : '0;
      endcase
    end
  end
endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
  parameter int XLEN   = 32,
  parameter int NCAUSE = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [NCAUSE-1:1] trap_req_i,
  input logic              rft_i,
  input logic              ex_we_i,
  input logic [7:0]        status_o,
  input logic              redirect_valid_o,
  input logic [XLEN-1:0]   redirect_pc_o,
  input logic              trap_taken_o,
  input logic              tlb_wr_en_o,
  input logic [XLEN-1:0]   epc_q
);
  // R1
  reset_kernel_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o[1:0] == 2'b01 && !redirect_valid_o));

  // R2
  trap_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (|trap_req_i) |=> (status_o[1:0] == 2'b01 && status_o[5:2] == $past(status_o[3:0])
                      && status_o[7:6] == $past(status_o[7:6])));

  // R3
  rft_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (rft_i && !(|trap_req_i) && !ex_we_i) |=>
      (status_o[3:0] == $past(status_o[5:2]) && status_o[7:4] == $past(status_o[7:4])
       && redirect_valid_o && redirect_pc_o == $past(epc_q)));

  // R4
  trap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|trap_req_i) |=> (trap_taken_o && redirect_valid_o));

  // R4
  taken_implies_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    trap_taken_o |-> redirect_valid_o);

  // R12
  tlb_wr_needs_we_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_wr_en_o |-> $past(ex_we_i));
endmodule

bind trap_ctl trap_ctl_chk #(.XLEN(XLEN), .NCAUSE(NCAUSE)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .trap_req_i       (trap_req_i),
  .rft_i            (rft_i),
  .ex_we_i          (ex_we_i),
  .status_o         (status_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .trap_taken_o     (trap_taken_o),
  .tlb_wr_en_o      (tlb_wr_en_o),
  .epc_q            (epc_q)
);

// File: tb/trap_ctl_bench.sv
module trap_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TV = 32'h8000_0100;
  localparam logic [31:0] MV = 32'h8000_0000;
  localparam logic [31:0] CV = 32'hBFC0_0200;

  logic        clk = 1'b0;
  logic        rst;
  logic [12:1] trap_req_i;
  logic        is_mcall_i, rft_i, ex_we_i;
  logic [31:0] trap_pc_i, trap_vaddr_i, ex_wdata_i, ex_rdata_o, tlb_rd_data_i;
  logic [4:0]  ex_addr_i;
  logic [2:0]  tlb_rd_idx_o, tlb_wr_idx_o;
  logic        tlb_wr_en_o, redirect_valid_o, trap_taken_o;
  logic [31:0] tlb_wr_data_o, redirect_pc_o;
  logic [7:0]  status_o;

  int checks = 0;
  int fails  = 0;

  trap_ctl u_trap_ctl (
    .clk(clk), .rst(rst), .trap_req_i(trap_req_i), .is_mcall_i(is_mcall_i),
    .trap_pc_i(trap_pc_i), .trap_vaddr_i(trap_vaddr_i), .rft_i(rft_i),
    .ex_addr_i(ex_addr_i), .ex_we_i(ex_we_i), .ex_wdata_i(ex_wdata_i),
    .ex_rdata_o(ex_rdata_o), .tlb_rd_data_i(tlb_rd_data_i),
    .tlb_rd_idx_o(tlb_rd_idx_o), .tlb_wr_en_o(tlb_wr_en_o),
    .tlb_wr_idx_o(tlb_wr_idx_o), .tlb_wr_data_o(tlb_wr_data_o),
    .status_o(status_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o), .trap_taken_o(trap_taken_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tlb_rd_data_i = 32'h5A00_0000 | {29'd0, tlb_rd_idx_o};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    ex_addr_i = a; ex_wdata_i = d; ex_we_i = 1'b1;
    step();
    ex_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    ex_addr_i = a;
    step();
    d = ex_rdata_o;
  endtask

  // raise requests for one cycle; outputs are sampled on the next negedge
  task automatic fire(input logic [12:1] r, input logic m, input logic [31:0] pc,
                      input logic [31:0] va);
    trap_req_i = r; is_mcall_i = m; trap_pc_i = pc; trap_vaddr_i = va;
    step();
    trap_req_i = '0; is_mcall_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [12:1] r;
    rst = 1'b1; trap_req_i = '0; is_mcall_i = 0; rft_i = 0; ex_we_i = 0;
    ex_addr_i = '0; ex_wdata_i = '0; trap_pc_i = '0; trap_vaddr_i = '0;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk("R1 status", {24'd0, status_o}, 32'h01);
    chk("R1 redirect", {31'd0, redirect_valid_o}, 32'd0);
    for (int a = 1; a < 8; a++) begin
      rd(5'(a), v);
      chk("R1 reg", v, 32'd0);
    end

    // R11 vectors written and read back, unmapped reads zero
    wr(5'h05, TV); wr(5'h06, MV); wr(5'h07, CV);
    rd(5'h05, v); chk("R11 vgen", v, TV);
    rd(5'h06, v); chk("R11 vmiss", v, MV);
    rd(5'h07, v); chk("R11 vmcall", v, CV);
    rd(5'h0A, v); chk("R11 unmapped", v, 32'd0);
    rd(5'h17, v); chk("R11 unmapped hi", v, 32'd0);

    // R4 R5 R6 every cause alone
    for (int k = 1; k <= 12; k++) begin
      logic [31:0] pc, va, ev;
      pc = 32'h400 + 32'(k) * 4;
      va = 32'h1000_0000 + 32'(k) * 32'h1111;
      wr(5'h03, 32'hDEAD_0000);
      r = '0; r[k] = 1'b1;
      fire(r, 1'b0, pc, va);
      chk("R4 valid", {31'd0, redirect_valid_o}, 32'd1);
      chk("R4 taken", {31'd0, trap_taken_o}, 32'd1);
      chk("R5 target", redirect_pc_o, (k == 3) ? MV : TV);
      rd(5'h01, v); chk("R4 cause", v, 32'(k));
      chk("R4 pulse ends", {31'd0, redirect_valid_o}, 32'd0);
      rd(5'h02, v); chk("R4 trap pc", v, pc);
      ev = (k >= 3 && k <= 9) ? va : 32'hDEAD_0000;
      rd(5'h03, v); chk("R6 badva", v, ev);
    end

    // R8 every pair of causes
    for (int i = 1; i <= 12; i++) begin
      for (int j = i + 1; j <= 12; j++) begin
        int w;
        w = (i == 1) ? j : i;
        r = '0; r[i] = 1'b1; r[j] = 1'b1;
        fire(r, 1'b0, 32'h800, 32'h0);
        chk("R8 target", redirect_pc_o, (w == 3) ? MV : TV);
        rd(5'h01, v); chk("R8 winner", v, 32'(w));
      end
    end

    // R2 R3 status stack
    wr(5'h00, 32'hFFFF_FFE7);
    chk("R11 status write", {24'd0, status_o}, 32'hE7);
    r = '0; r[10] = 1'b1;
    fire(r, 1'b0, 32'h2000, 32'h0);
    chk("R2 push", {24'd0, status_o}, 32'hDD);
    rft_i = 1'b1; step(); rft_i = 1'b0;
    chk("R3 rft pc", redirect_pc_o, 32'h2000);
    chk("R3 rft valid", {31'd0, redirect_valid_o}, 32'd1);
    chk("R3 pop", {24'd0, status_o}, 32'hD7);

    // R7 context
    wr(5'h15, 32'hFFFF_FFFF);
    r = '0; r[3] = 1'b1;
    fire(r, 1'b0, 32'h0, 32'h1234_5678);
    rd(5'h15, v); chk("R7 context", v, 32'hFFE4_8D14);
    r = '0; r[6] = 1'b1;
    fire(r, 1'b0, 32'h0, 32'h0000_1FFF);
    rd(5'h15, v); chk("R7 context low", v, 32'hFFE0_0004);

    // R9 mcall and kcall
    r = '0; r[2] = 1'b1;
    fire(r, 1'b1, 32'h0, 32'h0);
    chk("R9 kernel mcall", redirect_pc_o, CV);
    rd(5'h01, v); chk("R9 kernel mcall cause", v, 32'd2);
    wr(5'h00, 32'h0);
    fire(r, 1'b1, 32'h0, 32'h0);
    chk("R9 user mcall", redirect_pc_o, TV);
    chk("R9 back to kernel", {31'd0, status_o[0]}, 32'd1);
    rd(5'h01, v); chk("R9 user mcall cause", v, 32'd11);
    wr(5'h00, 32'h0);
    fire(r, 1'b0, 32'h0, 32'h0);
    chk("R9 user kcall", redirect_pc_o, TV);
    rd(5'h01, v); chk("R9 user kcall cause", v, 32'd2);

    // R10 user-mode write
    wr(5'h04, 32'h1234);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h9999);
    chk("R10 perm trap", {31'd0, redirect_valid_o}, 32'd1);
    chk("R10 target", redirect_pc_o, TV);
    rd(5'h01, v); chk("R10 cause", v, 32'd11);
    rd(5'h04, v); chk("R10 unchanged", v, 32'h1234);

    // R13 trap beats write and return
    wr(5'h04, 32'h55);
    trap_req_i = '0; trap_req_i[12] = 1'b1;
    wr(5'h04, 32'h77);
    trap_req_i = '0;
    chk("R13 trap vs write", redirect_pc_o, TV);
    rd(5'h04, v); chk("R13 write dropped", v, 32'h55);
    rd(5'h01, v); chk("R13 cause", v, 32'd12);
    rft_i = 1'b1;
    r = '0; r[10] = 1'b1;
    fire(r, 1'b0, 32'h3000, 32'h0);
    rft_i = 1'b0;
    chk("R13 trap vs rft", redirect_pc_o, TV);
    rd(5'h02, v); chk("R13 epc", v, 32'h3000);

    // R12 TLB pass-through
    wr(5'h11, 32'hCAFE_F00D);
    chk("R12 wr en", {31'd0, tlb_wr_en_o}, 32'd1);
    chk("R12 wr idx", {29'd0, tlb_wr_idx_o}, 32'd1);
    chk("R12 wr data", tlb_wr_data_o, 32'hCAFE_F00D);
    step();
    chk("R12 pulse ends", {31'd0, tlb_wr_en_o}, 32'd0);
    wr(5'h15, 32'h0);
    chk("R12 ctx no pulse", {31'd0, tlb_wr_en_o}, 32'd0);
    rd(5'h12, v); chk("R11 tlb read", v, 32'h5A00_0002);
    rd(5'h16, v); chk("R11 tlb read pd", v, 32'h5A00_0006);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule